// File: doc/BRIEF.md
# Scrolling Seven-Segment Message Display

This block moves a fixed message of 4-bit character codes from right to left across a four-digit, common-anode seven-segment display. The message is a parameter. Codes 0 to 9 show decimal digits, code D shows a dash, and the other letter codes show a blank. The block keeps the message in a circular character buffer. A slow scroll strobe rotates the buffer by one position, so the four leftmost buffer slots always form the visible window.

A faster scan divider steps a 2-bit digit select. For each select value, the block puts one window character on the shared segment lines and pulls one active-low digit enable low. Segment and enable outputs come from registers, so both change on the same clock edge and no digit shows its neighbour's data. A synchronous clear reloads the message and restarts both dividers. The decimal point stays dark at all times.

Top module: `scroll_display`

## Requirements
- R1: Segment outputs are active-low, with segment a on bit 6 and segment g on bit 0. Codes 0 to 9 give these values: 0=7'h01, 1=7'h4F, 2=7'h12, 3=7'h06, 4=7'h4C, 5=7'h24, 6=7'h20, 7=7'h0F, 8=7'h00, 9=7'h04.
- R2: Code 'hD lights only segment g (7'h7E). Codes 'hA, 'hB, 'hC, 'hE and 'hF light nothing (7'h7F).
- R3: After the first clock edge that follows a clear, exactly one of the four active-low digit enables is low on every cycle.
- R4: The decimal point output is always 1.
- R5: Scan select s (0..3) enables digit s, which drives enable bit s low. Select 0 gives 4'b1110 and is the rightmost digit. Select 3 gives 4'b0111 and is the leftmost digit. The select advances by one, wrapping from 3 to 0, every SCAN_DIV clock cycles. Select s shows window position 3-s, where position 0 is the leftmost digit.
- R6: Segments and enables are registered together. After n clock edges following the release of clear (n >= 1), they show the select value and the buffer contents as they stood after n-1 edges.
- R7: Character k of the message sits in MESSAGE bits [4*(MSG_LEN-1-k) +: 4], so character 0 is the most significant nibble. After clear, window positions 0 to 3 show characters 0 to 3.
- R8: Every SCROLL_DIV clock cycles, every character moves one position toward the leftmost digit. The leftmost buffer character wraps to the end of the buffer. After n edges the window has moved floor(n/SCROLL_DIV) steps, taken modulo MSG_LEN.
- R9: Clear is synchronous and active-high. While it is sampled high, the enables read 4'b1111 and the segments read 7'h7F, and both dividers and the message restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear, active-high |
| segN | output | 7 | Active-low segments, a on bit 6 to g on bit 0 |
| anN | output | 4 | Active-low digit enables, bit 0 is the rightmost digit |
| dp | output | 1 | Decimal point, held at 1 (off) |

## Verification
Each output pair comes from one register stage after the select and buffer state. The value sampled after edge n therefore depends on edge n-1: the select is floor((n-1)/SCAN_DIV) mod 4 and the scroll offset is floor((n-1)/SCROLL_DIV) mod MSG_LEN. The bench counts edges from the release of clear and samples on the falling clock edge after each rising edge. It rebuilds the expected enable and glyph from those two formulas over more than one full rotation of a sixteen-character message that contains every code. A clear applied mid-run is checked one edge after it is sampled (blank, all digits off), and again on the first edge after release (rightmost digit, fourth character).

// File: rtl/scroll_pkg.sv
package scroll_pkg;

  // Strobes from the timing control to the datapath
  typedef struct packed {
    logic scanStep;    // advance digit select
    logic scrollStep;  // rotate the message one place left
  } ctrlStrobes_t;

  localparam logic [6:0] SEG_BLANK = 7'h7F;
  localparam logic [3:0] AN_NONE   = 4'hF;

  // Active-low glyph, segment a on bit 6 .. g on bit 0
  function automatic logic [6:0] glyphOf(input logic [3:0] code);
    logic [6:0] g;
    case (code)
      4'h0: g = 7'h01;
      4'h1: g = 7'h4F;
      4'h2: g = 7'h12;
      4'h3: g = 7'h06;
      4'h4: g = 7'h4C;
      4'h5: g = 7'h24;
      4'h6: g = 7'h20;
      4'h7: g = 7'h0F;
      4'h8: g = 7'h00;
      4'h9: g = 7'h04;
      4'hD: g = 7'h7E;
      default: g = SEG_BLANK;
    endcase
    return g;
  endfunction

  // Active-low one-cold enable for a digit select
  function automatic logic [3:0] enableOf(input logic [1:0] sel);
    logic [3:0] e;
    e = AN_NONE;
    e[sel] = 1'b0;
    return e;
  endfunction

endpackage

// File: rtl/scroll_ctrl.sv
module scroll_ctrl
  import scroll_pkg::*;
#(
  parameter int SCAN_DIV   = 50000,
  parameter int SCROLL_DIV = 16666666
) (
  input  logic         clk,
  input  logic         clr,
  output ctrlStrobes_t strobes
);
  localparam int SCAN_W   = (SCAN_DIV > 1)   ? $clog2(SCAN_DIV)   : 1;
  localparam int SCROLL_W = (SCROLL_DIV > 1) ? $clog2(SCROLL_DIV) : 1;
  localparam logic [SCAN_W-1:0]   SCAN_LAST   = SCAN_W'(SCAN_DIV - 1);
  localparam logic [SCROLL_W-1:0] SCROLL_LAST = SCROLL_W'(SCROLL_DIV - 1);

  logic [SCAN_W-1:0]   scanCnt;
  logic [SCROLL_W-1:0] scrollCnt;
  logic scanWrap, scrollWrap;

  assign scanWrap   = (scanCnt == SCAN_LAST);
  assign scrollWrap = (scrollCnt == SCROLL_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      scanCnt   <= '0;
      scrollCnt <= '0;
    end else begin
      scanCnt   <= scanWrap   ? '0 : scanCnt + 1'b1;
      scrollCnt <= scrollWrap ? '0 : scrollCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.scanStep   = scanWrap & ~clr;
    strobes.scrollStep = scrollWrap & ~clr;
  end

endmodule

// File: rtl/scroll_datapath.sv
module scroll_datapath
  import scroll_pkg::*;
#(
  parameter int                  MSG_LEN = 12,
  parameter logic [MSG_LEN*4-1:0] MESSAGE = '1
) (
  input  logic         clk,
  input  logic         clr,
  input  ctrlStrobes_t strobes,
  output logic [6:0]   segOut,
  output logic [3:0]   anOut
);
  logic [3:0] charBuf [MSG_LEN];
  logic [3:0] window  [4];
  logic [1:0] scanSel;
  logic [1:0] winIdx;

  // Circular buffer, rotates toward slot 0 (leftmost)
  for (genvar k = 0; k < MSG_LEN; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (clr)
        charBuf[k] <= MESSAGE[4*(MSG_LEN-1-k) +: 4];
      else if (strobes.scrollStep)
        charBuf[k] <= charBuf[(k+1) % MSG_LEN];
    end
  end

  for (genvar p = 0; p < 4; p++) begin : g_win
    assign window[p] = charBuf[p];
  end

  assign winIdx = 2'd3 - scanSel;

  always_ff @(posedge clk) begin
    if (clr) begin
      scanSel <= '0;
      segOut  <= SEG_BLANK;
      anOut   <= AN_NONE;
    end else begin
      if (strobes.scanStep) scanSel <= scanSel + 2'd1;
      segOut <= glyphOf(window[winIdx]);
      anOut  <= enableOf(scanSel);
    end
  end

endmodule

// File: rtl/scroll_display.sv
module scroll_display #(
  parameter int                  MSG_LEN    = 12,
  parameter logic [MSG_LEN*4-1:0] MESSAGE    = 48'h947012D123FF,
  parameter int                  SCAN_DIV   = 50000,
  parameter int                  SCROLL_DIV = 16666666
) (
  input  logic       clk,
  input  logic       clr,
  output logic [6:0] segN,
  output logic [3:0] anN,
  output logic       dp
);
  scroll_pkg::ctrlStrobes_t strobes;

  scroll_ctrl #(
    .SCAN_DIV  (SCAN_DIV),
    .SCROLL_DIV(SCROLL_DIV)
  ) i_ctrl (
    .clk    (clk),
    .clr    (clr),
    .strobes(strobes)
  );

  scroll_datapath #(
    .MSG_LEN(MSG_LEN),
    .MESSAGE(MESSAGE)
  ) i_dp (
    .clk    (clk),
    .clr    (clr),
    .strobes(strobes),
    .segOut (segN),
    .anOut  (anN)
  );

  assign dp = 1'b1;

endmodule

// File: rtl/scroll_display_chk.sv
module scroll_display_chk (
  input logic       clk,
  input logic       clr,
  input logic [6:0] segN,
  input logic [3:0] anN,
  input logic       dp
);
  bit seenClr = 1'b0;
  bit armed   = 1'b0;
  bit armedQ  = 1'b0;

  always_ff @(posedge clk) begin
    seenClr <= seenClr | clr;
    armed   <= (seenClr | clr) & ~clr;
    armedQ  <= armed & ~clr;
  end

  // R4
  dp_dark_chk: assert property (@(posedge clk) disable iff (!seenClr) dp == 1'b1);

  // R3
  one_digit_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    $countones(anN) == 3);

  // R9
  clear_blank_chk: assert property (@(posedge clk) disable iff (!seenClr)
    clr |=> (anN == 4'hF && segN == 7'h7F));

  // R5
  scan_order_chk: assert property (@(posedge clk) disable iff (clr || !armedQ)
    (anN != $past(anN)) |-> (anN == {$past(anN[2:0]), $past(anN[3])}));

endmodule

bind scroll_display scroll_display_chk i_chk (
  .clk (clk),
  .clr (clr),
  .segN(segN),
  .anN (anN),
  .dp  (dp)
);

// File: tb/test_scroll_display.sv
module test_scroll_display;
  localparam int MSG_LEN    = 16;
  localparam logic [63:0] MSG = 64'h0123456789ABCDEF;
  localparam int SCAN_DIV   = 4;
  localparam int SCROLL_DIV = 64;
  localparam int RUN_EDGES  = 1100;

  // Expected active-low glyph per code (R1, R2)
  localparam logic [6:0] GLYPH [16] = '{
    7'h01, 7'h4F, 7'h12, 7'h06, 7'h4C, 7'h24, 7'h20, 7'h0F,
    7'h00, 7'h04, 7'h7F, 7'h7F, 7'h7F, 7'h7E, 7'h7F, 7'h7F};

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic [6:0] segN;
  logic [3:0] anN;
  logic dp;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scroll_display #(
    .MSG_LEN(MSG_LEN), .MESSAGE(MSG),
    .SCAN_DIV(SCAN_DIV), .SCROLL_DIV(SCROLL_DIV)
  ) i_scroll_display (
    .clk(clk), .clr(clr), .segN(segN), .anN(anN), .dp(dp)
  );

  function automatic logic [3:0] charAt(input int k);
    return MSG[4*(MSG_LEN-1-k) +: 4];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected outputs after n edges since clear release (R5, R6, R7, R8)
  task automatic checkEdge(input int n);
    int sel, steps, idx;
    logic [3:0] code;
    logic [3:0] expAn;
    sel   = ((n - 1) / SCAN_DIV) % 4;
    steps = ((n - 1) / SCROLL_DIV) % MSG_LEN;
    idx   = (3 - sel + steps) % MSG_LEN;
    code  = charAt(idx);
    expAn = 4'hF;
    expAn[sel] = 1'b0;
    check("R5/R6 enable", {28'd0, anN}, {28'd0, expAn});
    if (code <= 4'h9)
      check("R1/R7/R8 digit glyph", {25'd0, segN}, {25'd0, GLYPH[code]});
    else
      check("R2/R7/R8 letter glyph", {25'd0, segN}, {25'd0, GLYPH[code]});
    check("R3 single digit", $countones(anN), 32'd3);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 reset enables", {28'd0, anN}, 32'hF);
    check("R9 reset segments", {25'd0, segN}, 32'h7F);
    check("R4 dp off", {31'd0, dp}, 32'd1);
    clr = 1'b0;

    // Walk beyond one full rotation of the message
    for (int n = 1; n <= RUN_EDGES; n++) begin
      @(posedge clk);
      @(negedge clk);
      checkEdge(n);
      if (n % 97 == 0) check("R4 dp off", {31'd0, dp}, 32'd1);
    end

    // R9: clear mid-run, then R7 restart window
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 mid-run clear enables", {28'd0, anN}, 32'hF);
    check("R9 mid-run clear segments", {25'd0, segN}, 32'h7F);
    clr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R7 restart rightmost", {28'd0, anN}, 32'hE);
    check("R7 restart fourth char", {25'd0, segN}, {25'd0, GLYPH[charAt(3)]});
    for (int n = 2; n <= 3 * SCROLL_DIV; n++) begin
      @(posedge clk);
      @(negedge clk);
      checkEdge(n);
    end
    check("R4 dp off", {31'd0, dp}, 32'd1);
    finishRun();
  end

endmodule